// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers interrupt events from the channels of a DMA engine and presents them to software through a small word-addressed register port. Each channel can raise four kinds of event: completion of a whole descriptor chain, completion of an individual descriptor that was flagged for notification, and two independent error classes. Every event class keeps, per channel, a sticky pending bit, an enable bit and a derived enabled-pending bit. A per-channel summary folds the four enabled-pending bits together, and one level-sensitive interrupt line is high while any summary bit is set.

Software enables sources by writing the enable registers (a 1 enables a channel), reads the summary and per-class status to find which channels need service, and acknowledges by writing ones into the pending registers. Event pulses arrive as one bitmap per class, bit i belonging to channel i, and are captured whether or not the channel is enabled.

Top module: `irqc_top`

## Requirements
- R1: After reset all pending and enable bits are 0, the interrupt line is low and every mapped register reads 0.
- R2: A 1 on bit i of an event input in a cycle sets that class's pending bit i at the next clock edge; the bit then stays set until software clears it. Pending registers read at byte offsets 0x600 (chain done), 0x608 (descriptor done), 0x610 (error A), 0x618 (error B), channel i at bit i.
- R3: A write to a pending register clears exactly the bits written as 1 and leaves bits written as 0 unchanged.
- R4: When an event and a write-1 clear hit the same pending bit in the same cycle, the bit ends up set.
- R5: Enable registers at 0x018, 0x01C, 0x020, 0x024 (same class order) load write data bits 15:0 on a write, hold otherwise, and read back with bits 31:16 as 0.
- R6: Status registers at 0x004, 0x008, 0x00C, 0x010 (same class order) read as pending AND enable, bit for bit.
- R7: The summary register at 0x000 has bit i set when any of channel i's four status bits is set.
- R8: The interrupt output is high exactly when the summary register is non-zero.
- R9: Writes to the summary, the status registers or unmapped offsets change no state; reads of unmapped offsets return 0, and the read data is 0 whenever the read strobe is low.
- R10: Disabled channels still capture events into their pending bits; only status, summary and the interrupt line are gated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address and strobe |
| tc1_evt | input | 16 | Chain-complete event pulses, one per channel |
| tc2_evt | input | 16 | Descriptor-complete event pulses, one per channel |
| err1_evt | input | 16 | Error class A event pulses, one per channel |
| err2_evt | input | 16 | Error class B event pulses, one per channel |
| irq | output | 1 | Level interrupt request |

## Verification
The checker watches every cycle that pending bits rise only after an event, that an event always leaves its bit set (even against a simultaneous clear), that pending bits fall only on a write to their own pending register, that enable registers move only on their own writes, and that the interrupt line matches the OR of pending AND enable. The exact register values on readback, the address decode of all thirteen registers, the handling of writes to read-only and unmapped offsets and the zero upper bits are only shown by the bench's directed and random scenarios compared against its own register model.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int N_SRC = 4;

    typedef enum logic [1:0] {
        SRC_CHAIN = 2'd0,
        SRC_NODE  = 2'd1,
        SRC_ERRA  = 2'd2,
        SRC_ERRB  = 2'd3
    } src_e;

    localparam logic [11:0] SUMMARY_OFS = 12'h000;

    function automatic logic [11:0] stat_ofs(input int s);
        return 12'h004 + 12'(4 * s);
    endfunction

    function automatic logic [11:0] mask_ofs(input int s);
        return 12'h018 + 12'(4 * s);
    endfunction

    function automatic logic [11:0] raw_ofs(input int s);
        return 12'h600 + 12'(8 * s);
    endfunction

endpackage

// File: rtl/irqc_bank.sv
module irqc_bank #(
    parameter int N_CH = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] evt,
    input  logic            clr_en,
    input  logic [N_CH-1:0] clr_bits,
    input  logic            mask_en,
    input  logic [N_CH-1:0] mask_bits,
    output logic [N_CH-1:0] raw,
    output logic [N_CH-1:0] mask,
    output logic [N_CH-1:0] stat
);

    logic [N_CH-1:0] clr_eff;

    assign clr_eff = clr_en ? clr_bits : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw  <= '0;
            mask <= '0;
        end else begin
            raw <= (raw & ~clr_eff) | evt;
            if (mask_en) begin
                mask <= mask_bits;
            end
        end
    end

    assign stat = raw & mask;

endmodule

// File: rtl/irqc_rdmux.sv
module irqc_rdmux
    import irqc_pkg::*;
#(
    parameter int N_CH   = 16,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic                        rd,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [N_SRC-1:0][N_CH-1:0]  raw,
    input  logic [N_SRC-1:0][N_CH-1:0]  mask,
    input  logic [N_SRC-1:0][N_CH-1:0]  stat,
    input  logic [N_CH-1:0]             summary,
    output logic [DATA_W-1:0]           rdata
);

    always_comb begin
        rdata = '0;
        if (rd) begin
            if (addr == ADDR_W'(SUMMARY_OFS)) begin
                rdata = DATA_W'(summary);
            end
            for (int s = 0; s < N_SRC; s++) begin
                if (addr == ADDR_W'(stat_ofs(s))) rdata = DATA_W'(stat[s]);
                if (addr == ADDR_W'(mask_ofs(s))) rdata = DATA_W'(mask[s]);
                if (addr == ADDR_W'(raw_ofs(s)))  rdata = DATA_W'(raw[s]);
            end
        end
    end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int N_CH   = 16,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [N_CH-1:0]   tc1_evt,
    input  logic [N_CH-1:0]   tc2_evt,
    input  logic [N_CH-1:0]   err1_evt,
    input  logic [N_CH-1:0]   err2_evt,
    output logic              irq
);

    logic [N_SRC-1:0][N_CH-1:0] evt_all;
    logic [N_SRC-1:0][N_CH-1:0] raw_q;
    logic [N_SRC-1:0][N_CH-1:0] mask_q;
    logic [N_SRC-1:0][N_CH-1:0] stat_w;
    logic [N_CH-1:0]            summary;

    assign evt_all[SRC_CHAIN] = tc1_evt;
    assign evt_all[SRC_NODE]  = tc2_evt;
    assign evt_all[SRC_ERRA]  = err1_evt;
    assign evt_all[SRC_ERRB]  = err2_evt;

    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        logic clr_hit;
        logic mask_hit;

        assign clr_hit  = reg_wr && (reg_addr == ADDR_W'(raw_ofs(s)));
        assign mask_hit = reg_wr && (reg_addr == ADDR_W'(mask_ofs(s)));

        irqc_bank #(.N_CH(N_CH)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt       (evt_all[s]),
            .clr_en    (clr_hit),
            .clr_bits  (reg_wdata[N_CH-1:0]),
            .mask_en   (mask_hit),
            .mask_bits (reg_wdata[N_CH-1:0]),
            .raw       (raw_q[s]),
            .mask      (mask_q[s]),
            .stat      (stat_w[s])
        );
    end

    always_comb begin
        summary = '0;
        for (int s = 0; s < N_SRC; s++) begin
            summary = summary | stat_w[s];
        end
    end

    assign irq = |summary;

    irqc_rdmux #(.N_CH(N_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rdmux (
        .rd      (reg_rd),
        .addr    (reg_addr),
        .raw     (raw_q),
        .mask    (mask_q),
        .stat    (stat_w),
        .summary (summary),
        .rdata   (reg_rdata)
    );

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
    import irqc_pkg::*;
#(
    parameter int N_CH   = 16,
    parameter int ADDR_W = 12
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       reg_wr,
    input logic [ADDR_W-1:0]          reg_addr,
    input logic [N_SRC-1:0][N_CH-1:0] evt,
    input logic [N_SRC-1:0][N_CH-1:0] raw,
    input logic [N_SRC-1:0][N_CH-1:0] mask,
    input logic                       irq
);

    logic [N_CH-1:0] enabled_any;

    always_comb begin
        enabled_any = '0;
        for (int s = 0; s < N_SRC; s++) begin
            enabled_any = enabled_any | (raw[s] & mask[s]);
        end
    end

    for (genvar s = 0; s < N_SRC; s++) begin : g_chk
        // R2 and R4: an event always leaves its pending bit set
        assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[s] != '0) |=> ((raw[s] & $past(evt[s])) == $past(evt[s])));

        // R2: a pending bit rises only after an event on it
        assert_rise_needs_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> ((raw[s] & ~$past(raw[s]) & ~$past(evt[s])) == '0));

        // R3 and R9: pending bits fall only on a write to their own register
        assert_fall_needs_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !(reg_wr && reg_addr == ADDR_W'(raw_ofs(s)))
            |=> ((raw[s] & $past(raw[s])) == $past(raw[s])));

        // R5 and R9: enable bits move only on their own write
        assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !(reg_wr && reg_addr == ADDR_W'(mask_ofs(s))) |=> $stable(mask[s]));
    end

    // R8: interrupt line follows enabled pending bits
    assert_irq_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (enabled_any != '0));

endmodule

bind irqc_top irqc_chk #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .evt      (evt_all),
    .raw      (raw_q),
    .mask     (mask_q),
    .irq      (irq)
);

// File: tb/sim_irqc_top.sv
module sim_irqc_top;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;
    localparam int NC = 16;
    localparam int N_ITER = 400;

    logic        clk;
    logic        rst_n;
    logic        reg_wr;
    logic        reg_rd;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [15:0] tc1_evt, tc2_evt, err1_evt, err2_evt;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [15:0] m_raw  [NS];
    logic [15:0] m_mask [NS];

    irqc_top u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tc1_evt(tc1_evt), .tc2_evt(tc2_evt), .err1_evt(err1_evt),
        .err2_evt(err2_evt), .irq(irq)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [11:0] a_stat(int s); return 12'h004 + 12'(4 * s); endfunction
    function automatic logic [11:0] a_mask(int s); return 12'h018 + 12'(4 * s); endfunction
    function automatic logic [11:0] a_raw(int s);  return 12'h600 + 12'(8 * s); endfunction

    function automatic logic [15:0] exp_summary();
        logic [15:0] v = '0;
        for (int s = 0; s < NS; s++) v |= m_raw[s] & m_mask[s];
        return v;
    endfunction

    function automatic logic [31:0] exp_read(logic [11:0] a);
        if (a == 12'h000) return {16'h0, exp_summary()};
        for (int s = 0; s < NS; s++) begin
            if (a == a_stat(s)) return {16'h0, m_raw[s] & m_mask[s]};
            if (a == a_mask(s)) return {16'h0, m_mask[s]};
            if (a == a_raw(s))  return {16'h0, m_raw[s]};
        end
        return 32'h0;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic read_check(string req, logic [11:0] a);
        reg_rd   = 1'b1;
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp_read(a));
        reg_rd   = 1'b0;
        reg_addr = '0;
        #1;
    endtask

    task automatic check_all();
        read_check("R7 summary", 12'h000);
        for (int s = 0; s < NS; s++) begin
            read_check("R6 status", a_stat(s));
            read_check("R5 enable", a_mask(s));
            read_check("R2 pending", a_raw(s));
        end
        check("R8 irq", {31'h0, irq}, {31'h0, exp_summary() != 16'h0});
    endtask

    // one clock: apply events and an optional write, then update the model
    task automatic step(logic [NS-1:0][15:0] e, bit wr, logic [11:0] a, logic [31:0] d);
        tc1_evt = e[0]; tc2_evt = e[1]; err1_evt = e[2]; err2_evt = e[3];
        reg_wr = wr; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1;
        for (int s = 0; s < NS; s++) begin
            logic [15:0] clr;
            clr = (wr && a == a_raw(s)) ? d[15:0] : 16'h0;
            m_raw[s] = (m_raw[s] & ~clr) | e[s];
            if (wr && a == a_mask(s)) m_mask[s] = d[15:0];
        end
        tc1_evt = '0; tc2_evt = '0; err1_evt = '0; err2_evt = '0;
        reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [NS-1:0][15:0] e;
        void'($urandom(32'd4242));
        rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
        tc1_evt = '0; tc2_evt = '0; err1_evt = '0; err2_evt = '0;
        for (int s = 0; s < NS; s++) begin m_raw[s] = '0; m_mask[s] = '0; end
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1 irq", {31'h0, irq}, 32'h0);
        read_check("R1 summary", 12'h000);
        read_check("R1 pending", a_raw(3));
        read_check("R1 enable", a_mask(0));
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R10: disabled channel still captures
        e = '0; e[0] = 16'h0021;
        step(e, 0, 12'h0, 32'h0);
        check("R10 pending captured", {16'h0, m_raw[0]}, 32'h21);
        read_check("R10 pending", a_raw(0));
        read_check("R10 status gated", a_stat(0));
        check("R10 irq low", {31'h0, irq}, 32'h0);

        // R5: enable write, upper bits read 0
        e = '0;
        step(e, 1, a_mask(0), 32'hFFFF_0001);
        read_check("R5 upper bits", a_mask(0));
        check("R8 irq high", {31'h0, irq}, 32'h1);

        // R3: zero bits leave pending
        step(e, 1, a_raw(0), 32'h0000_0020);
        read_check("R3 partial clear", a_raw(0));
        check("R3 value", {16'h0, m_raw[0]}, 32'h1);

        // R4: set and clear collide
        e[1] = 16'h0008;
        step(e, 1, a_raw(1), 32'h0000_0008);
        read_check("R4 set wins", a_raw(1));
        check("R4 value", {16'h0, m_raw[1]}, 32'h8);

        // R9: writes to read-only and unmapped offsets ignored
        e = '0;
        step(e, 1, a_stat(1), 32'hFFFF_FFFF);
        step(e, 1, 12'h000, 32'hFFFF_FFFF);
        step(e, 1, 12'h604, 32'hFFFF_FFFF);
        check_all();
        read_check("R9 unmapped 0x014", 12'h014);
        read_check("R9 unmapped 0x604", 12'h604);
        read_check("R9 unmapped 0x7FC", 12'h7FC);
        reg_addr = a_raw(1); reg_rd = 1'b0; #1;
        check("R9 no strobe", reg_rdata, 32'h0);
        reg_addr = '0; #1;

        // random mix
        for (int it = 0; it < N_ITER; it++) begin
            int op;
            int src;
            logic [31:0] d;
            for (int s = 0; s < NS; s++) e[s] = 16'($urandom & $urandom & $urandom);
            op  = int'($urandom % 8);
            src = int'($urandom % NS);
            d   = $urandom;
            case (op)
                0, 1, 2: step(e, 1, a_raw(src), d);
                3, 4:    step(e, 1, a_mask(src), d);
                5:       step(e, 1, a_stat(src), d);
                6:       step(e, 1, 12'h02C, d);
                default: step(e, 0, 12'h0, 32'h0);
            endcase
            check_all();
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule